// File: doc/BRIEF.md
# Gang-Enabled Event Counter Group

This block holds five event counters that run under one shared run control. Each counter has its own event-select register that picks which of the incoming per-cycle event strobes it counts. A code can also ask the counter to count every clock, or to count nothing. Software cannot start, stop or clear one counter on its own. It writes the shared enable register, and a write of 1 zeroes all five counters and starts them together. A write of 0 freezes them so that their values can be read as one consistent snapshot.

Reprogramming and counting are interlocked. Any write to an event-select register stops the whole group in the same cycle. The enable register reads back the live run state, so software sees the group stop itself after a reselection. A normal session has four steps: program the selects, write 1 to enable, write 0 after a measurement window, then read the counters.

Register access goes through a single-cycle write port and a read port. Read data is registered and returned one cycle after the request.

Top module: `gcg_counter_group`

## Requirements
- R1: After a synchronous reset, the run state is 0, every select register holds 0x00, and every counter reads 0.
- R2: While the group runs and no control write (to the enable register or to any select register) happens in that cycle, a counter whose code c lies in 0x02..0x2B increases by one on each clock edge where `evt_i[c-2]` is high. Code 0x01 increases the counter on every such edge. The bank-0 hit, bank-1 hit, bank-0 miss and bank-1 miss codes are 0x17, 0x18, 0x19 and 0x1A, which map to event bits 21, 22, 23 and 24.
- R3: A write to the enable register with bit 0 set clears all counters to 0 at that edge and leaves the group running. This also happens when the group is already running. Counting resumes on the following edge.
- R4: A write to any select register stores the new 8-bit code and stops the whole group at that edge. Afterwards the enable register reads 0 and no counter changes.
- R5: While the group is stopped, for example after a write of 0 to the enable register, every counter holds its value whatever the event strobes do.
- R6: Code 0x00 and every code above 0x2B never advance their counter, even when all event strobes are high.
- R7: The register map is: address 0 is enable (bit 0), addresses 1 to 5 are the selects of counters 0 to 4, and addresses 8 to 12 are counters 0 to 4 (read only). `rd_valid` rises one cycle after `rd_en`. `rd_data` then shows the values from before that edge.
- R8: Writes to counter addresses and to unmapped addresses change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 42 | Per-cycle event strobes, bit k belongs to code k+2 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The assertions check these rules on every clock:
- a clear leaves every counter at zero;
- a counter either holds or steps by exactly one;
- a stopped or idle-coded counter stays frozen;
- a select write always leaves the group stopped;
- read data comes back one cycle after the request.

Only the bench scenarios can show that the right event bit reaches the right counter and that the counts over a window match. They also show that a control-write cycle is not counted, that a second start while running zeroes the counts, and that writes to counter and unmapped addresses leave the visible state untouched.

// File: rtl/gcg_pkg.sv
`timescale 1ns/1ps
package gcg_pkg;
  localparam int CODE_OFF        = 0;
  localparam int CODE_EVERY_CLK  = 1;
  localparam int CODE_FIRST_EVT  = 2;
  localparam int CODE_LAST       = 43;
  localparam int ADDR_ENABLE     = 0;
  localparam int ADDR_SEL_BASE   = 1;
  localparam int ADDR_CNT_BASE   = 8;

  typedef enum logic {
    GRP_STOPPED = 1'b0,
    GRP_RUNNING = 1'b1
  } grp_state_e;
endpackage

// File: rtl/gcg_ctrl.sv
`timescale 1ns/1ps
module gcg_ctrl
  import gcg_pkg::*;
#(
  parameter int NUM_CTR = 5,
  parameter int SEL_W   = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [SEL_W-1:0]                wr_data,
  output logic                            run_o,
  output logic                            clr_all_o,
  output logic                            go_o,
  output logic [NUM_CTR-1:0][SEL_W-1:0]   sel_o
);
  grp_state_e         state_q;
  logic               wr_enable;
  logic [NUM_CTR-1:0] wr_sel_vec;
  logic               any_sel_wr;

  assign wr_enable  = wr_en && (wr_addr == ADDR_W'(ADDR_ENABLE));
  assign any_sel_wr = |wr_sel_vec;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_sel
    assign wr_sel_vec[i] = wr_en && (wr_addr == ADDR_W'(ADDR_SEL_BASE + i));

    always_ff @(posedge clk) begin
      if (rst)                sel_o[i] <= SEL_W'(CODE_OFF);
      else if (wr_sel_vec[i]) sel_o[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             state_q <= GRP_STOPPED;
    else if (wr_enable)  state_q <= wr_data[0] ? GRP_RUNNING : GRP_STOPPED;
    else if (any_sel_wr) state_q <= GRP_STOPPED;
  end

  assign run_o     = (state_q == GRP_RUNNING);
  assign clr_all_o = wr_enable && wr_data[0];
  assign go_o      = run_o && !wr_enable && !any_sel_wr;

  AST_SEL_WRITE_STOPS: assert property (@(posedge clk) disable iff (rst)
    any_sel_wr |=> !run_o); // R4
  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    (wr_enable && wr_data[0]) |=> run_o); // R3
endmodule

// File: rtl/gcg_evt_mux.sv
`timescale 1ns/1ps
module gcg_evt_mux
  import gcg_pkg::*;
#(
  parameter int SEL_W   = 8,
  parameter int NUM_EVT = CODE_LAST - CODE_FIRST_EVT + 1
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    if (sel_i == SEL_W'(CODE_EVERY_CLK)) hit_o = 1'b1;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (sel_i == SEL_W'(k + CODE_FIRST_EVT)) hit_o = evt_i[k];
    end
  end
endmodule

// File: rtl/gcg_counter.sv
`timescale 1ns/1ps
module gcg_counter #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CTR_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (inc_i)   cnt_o <= cnt_o + CTR_W'(1);
  end

  AST_ZERO_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0)); // R3
  AST_HOLD_WITHOUT_INC: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !inc_i) |=> $stable(cnt_o)); // R5
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && inc_i) |=> (cnt_o == $past(cnt_o) + CTR_W'(1))); // R2
endmodule

// File: rtl/gcg_counter_group.sv
`timescale 1ns/1ps
module gcg_counter_group
  import gcg_pkg::*;
#(
  parameter int NUM_CTR = 5,
  parameter int CTR_W   = 32,
  parameter int SEL_W   = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = CODE_LAST - CODE_FIRST_EVT + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [SEL_W-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid
);
  logic                          run;
  logic                          clr_all;
  logic                          go;
  logic [NUM_CTR-1:0][SEL_W-1:0] sel;
  logic [NUM_CTR-1:0]            hit;
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
  logic [DATA_W-1:0]             rd_mux;

  gcg_ctrl #(.NUM_CTR(NUM_CTR), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .run_o     (run),
    .clr_all_o (clr_all),
    .go_o      (go),
    .sel_o     (sel)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    gcg_evt_mux #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_mux (
      .sel_i (sel[i]),
      .evt_i (evt_i),
      .hit_o (hit[i])
    );

    gcg_counter #(.CTR_W(CTR_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr_i (clr_all),
      .inc_i (go && hit[i]),
      .cnt_o (cnt[i])
    );

    AST_IDLE_CODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (((sel[i] == SEL_W'(CODE_OFF)) || (sel[i] > SEL_W'(CODE_LAST))) && !clr_all)
      |=> $stable(cnt[i])); // R6
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(ADDR_ENABLE)) rd_mux = DATA_W'(run);
    for (int i = 0; i < NUM_CTR; i++) begin
      if (rd_addr == ADDR_W'(ADDR_SEL_BASE + i)) rd_mux = DATA_W'(sel[i]);
      if (rd_addr == ADDR_W'(ADDR_CNT_BASE + i)) rd_mux = DATA_W'(cnt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R7
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R7
endmodule

// File: tb/tb_gcg_counter_group.sv
`timescale 1ns/1ps
module tb_gcg_counter_group;
  localparam int NUM_EVT = 42;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_EVT-1:0] evt_i = '0;
  logic               wr_en = 1'b0;
  logic [3:0]         wr_addr = '0;
  logic [7:0]         wr_data = '0;
  logic               rd_en = 1'b0;
  logic [3:0]         rd_addr = '0;
  logic [31:0]        rd_data;
  logic               rd_valid;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gcg_counter_group dut (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Monitor: pops one expected item per returned read.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: unexpected rd_valid, actual data %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n, input logic [NUM_EVT-1:0] ev);
    evt_i = ev;
    repeat (n) @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'd0, 32'd0, "R1 enable after reset");
    rd(4'd1, 32'd0, "R1 select0 after reset");
    rd(4'd8, 32'd0, "R1 counter0 after reset");

    // Program: cycles, bank0 hit, bank0 miss, off, out-of-range
    wr(4'd1, 8'h01);
    wr(4'd2, 8'h17);
    wr(4'd3, 8'h19);
    wr(4'd4, 8'h00);
    wr(4'd5, 8'h2C);
    rd(4'd2, 32'h17, "R7 select1 readback");

    // R2/R3: start, 10 counted cycles, stop
    wr(4'd0, 8'h01);
    for (int i = 0; i < 10; i++) begin
      evt_i = '1;
      evt_i[21] = (i < 6);
      evt_i[23] = (i % 3 == 0);
      @(negedge clk);
    end
    evt_i = '0;
    wr(4'd0, 8'h00);
    rd(4'd8,  32'd10, "R2 cycle-code counter");
    rd(4'd9,  32'd6,  "R2 bank0 hit counter");
    rd(4'd10, 32'd4,  "R2 bank0 miss counter");
    rd(4'd11, 32'd0,  "R6 code 0x00 counter");
    rd(4'd12, 32'd0,  "R6 code 0x2C counter");

    // R5 hold while stopped
    idle(5, '1);
    rd(4'd9, 32'd6,  "R5 hit counter held");
    rd(4'd8, 32'd10, "R5 cycle counter held");
    rd(4'd0, 32'd0,  "R5 enable reads stopped");

    // R3 enable zeroes
    wr(4'd0, 8'h01);
    wr(4'd0, 8'h00);
    rd(4'd8, 32'd0, "R3 cycle counter zeroed");
    rd(4'd9, 32'd0, "R3 hit counter zeroed");

    // R4 reselection stops the group
    wr(4'd0, 8'h01);
    idle(4, '1);
    evt_i = '1;
    wr(4'd3, 8'h18);
    idle(3, '1);
    rd(4'd0,  32'd0,  "R4 enable reads 0 after reselect");
    rd(4'd8,  32'd4,  "R4 cycle counter frozen");
    rd(4'd10, 32'd4,  "R4 reselected counter frozen");
    rd(4'd3,  32'h18, "R4 new code stored");
    rd(4'd12, 32'd0,  "R6 out-of-range code with all strobes");

    // R3 restart while running
    wr(4'd0, 8'h01);
    evt_i[22] = 1'b1;
    rd(4'd0, 32'd1, "R3 enable reads running");
    @(negedge clk);
    wr(4'd0, 8'h01);
    @(negedge clk);
    @(negedge clk);
    wr(4'd0, 8'h00);
    evt_i = '0;
    rd(4'd8,  32'd2, "R3 restart while running zeroes");
    rd(4'd10, 32'd2, "R2 bank1 hit counter");

    // R8 ignored writes and unmapped reads
    wr(4'd8, 8'h55);
    wr(4'd7, 8'h01);
    rd(4'd8,  32'd2, "R8 counter write ignored");
    rd(4'd0,  32'd0, "R8 unmapped write did not start");
    rd(4'd15, 32'd0, "R8 unmapped read");
    rd(4'd6,  32'd0, "R8 gap address read");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule